// File: doc/BRIEF.md
# Fastlock Timer and Power-Down Controller

This block sits beside the reference and feedback dividers and the charge pump of a frequency synthesizer. It picks which of two 3-bit charge-pump current codes drives the pump: a slow code for steady operation and a fast code for fast settling. The choice follows a stored gain bit, and three fastlock policies set how that bit is cleared. With fastlock off, the bit selects a code and keeps it. In software-exit mode the fast code stays until software writes the bit back to zero. In timed-exit mode the fast code lasts for a programmable number of phase-detector cycles, and then the block clears the bit itself.

The same block sequences power-down. A low chip-enable forces power-down on the next clock edge. A programmed immediate request does the same. A programmed deferred request arms first and then waits for a rising edge on either divider output, so that the pump is never cut off in the middle of a correction. While powered down, both dividers are held at their load point, the pump output is three-stated and the fastlock timer is kept at zero. A divider-reset field holds the dividers and floats the pump without powering down. All inputs are decoded configuration fields or plain pins, synchronous to `clk`. There is no streamed data, so there is no valid/ready interface.

Top module: `fl_pd_ctrl`

## Requirements
- R1: While reset is applied and right after it, `icp_sel` equals `icp_slow` and `pwr_down`, `cp_hiz` and both `div_hold` bits are 0.
- R2: A `gain_wr` pulse stores `gain_wdata` in the gain bit on that clock edge. From that edge on, `icp_sel` shows `icp_fast` when the bit is 1 and `icp_slow` when it is 0. With `fl_enable` = 0 the bit never clears by itself, however many ticks arrive.
- R3: With `fl_enable` = 1 and `fl_timed` = 0 (software exit), the fast code stays selected through any number of `pfd_tick` pulses until a write of 0.
- R4: With `fl_enable` = 1 and `fl_timed` = 1 (timed exit), writing 1 selects the fast code for exactly 3 + 4·`tmo_code` ticks. On the edge that samples the last of those ticks, the gain bit clears, so the slow code stays selected even after fastlock is then disabled.
- R5: The timeout counter advances only in timed-exit mode while the gain bit is 1. Each new write of 1 restarts the count from zero.
- R6: With `chip_en` = 0, `pwr_down` is 1 after the next clock edge, whatever `pd_arm` and `pd_defer` hold.
- R7: With `chip_en` = 1, `pd_arm` = 1 and `pd_defer` = 0, `pwr_down` is 1 after the next clock edge.
- R8: With `chip_en` = 1, `pd_arm` = 1 and `pd_defer` = 1, the request arms and `pwr_down` stays 0. It rises on the first edge that sees a bit of `div_out` (bit 0 reference, bit 1 feedback) at 1 after it was 0 on the previous edge while armed.
- R9: While `pwr_down` = 1, `cp_hiz` = 1 and both `div_hold` bits are 1. The timeout counter is held at zero, so a full timeout is needed after release.
- R10: `div_reset` = 1 sets both `div_hold` bits and `cp_hiz` after the next edge, but never raises `pwr_down` and never completes an armed deferred request.
- R11: `cp_float` = 1 sets `cp_hiz` after the next edge and leaves `pwr_down` and `div_hold` at 0.
- R12: When every power-down cause is removed, `pwr_down`, `cp_hiz` and both `div_hold` bits clear on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_enable | input | 1 | Fastlock enable field |
| fl_timed | input | 1 | Fastlock exit policy: 0 software, 1 timer |
| gain_wr | input | 1 | Strobe writing the gain bit |
| gain_wdata | input | 1 | Value written to the gain bit |
| tmo_code | input | 4 | Timeout code, length 3 + 4·code ticks |
| icp_slow | input | 3 | Steady-state current code |
| icp_fast | input | 3 | Fast-settling current code |
| chip_en | input | 1 | Chip enable pin, low forces power-down |
| pd_arm | input | 1 | Programmed power-down request |
| pd_defer | input | 1 | Defer the request to the next pump event |
| div_reset | input | 1 | Divider reset field |
| cp_float | input | 1 | Pump three-state field |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector cycle |
| div_out | input | 2 | Divider outputs, bit 0 reference, bit 1 feedback |
| icp_sel | output | 3 | Active charge-pump current code |
| cp_hiz | output | 1 | Charge-pump three-state flag |
| pwr_down | output | 1 | Block is in power-down |
| div_hold | output | 2 | Per-divider hold at load point |

## Verification
The gain bit and `icp_sel` follow a write on the clock edge that samples `gain_wr`. A timed-exit return to the slow code appears on the edge that samples the final counted tick. `pwr_down`, `cp_hiz` and `div_hold` are registered, so each one follows its cause one edge later. For a deferred request, the edge that counts is the one that samples the divider rise. The bench drives inputs and samples outputs on the falling clock edge, with each tick a separate one-cycle pulse. Every check therefore falls exactly one rising edge after the stimulus that should take effect, and the counted timeouts are probed one tick short of expiry and again at expiry.

// File: rtl/fl_pd_pkg.sv
package fl_pd_pkg;

  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_ARMED = 2'd1,
    PD_DOWN  = 2'd2
  } pd_state_t;

  // Longest timeout, in ticks, for a code of the given width
  function automatic int max_timeout(input int code_w, input int base, input int step);
    return base + step * ((1 << code_w) - 1);
  endfunction

endpackage

// File: rtl/fl_timeout_timer.sv
module fl_timeout_timer #(
  parameter int TC_W = 4,
  parameter int BASE = 3,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  input  logic [TC_W-1:0] tmo_code,
  output logic            expire
);
  localparam int MAX_LEN = fl_pd_pkg::max_timeout(TC_W, BASE, STEP);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             last;

  assign limit  = CNT_W'(BASE) + CNT_W'(STEP) * CNT_W'(tmo_code);
  assign last   = (cnt_q == (limit - CNT_W'(1)));
  assign expire = run && !restart && tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R5: a stopped timer never reports expiry on the following cycle
  p_idle_no_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/fl_gain_ctrl.sv
module fl_gain_ctrl #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gain_wr,
  input  logic              gain_wdata,
  input  logic              expire,
  input  logic [CODE_W-1:0] icp_slow,
  input  logic [CODE_W-1:0] icp_fast,
  output logic              gain_q,
  output logic [CODE_W-1:0] icp_sel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= 1'b0;
    end else if (gain_wr) begin
      gain_q <= gain_wdata;
    end else if (expire) begin
      gain_q <= 1'b0;
    end
  end

  assign icp_sel = gain_q ? icp_fast : icp_slow;

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr |=> (gain_q == $past(gain_wdata)));

  p_expiry_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !gain_wr) |=> !gain_q);

endmodule

// File: rtl/pd_edge_det.sv
module pd_edge_det #(
  parameter int NDIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIV-1:0] sig_in,
  output logic [NDIV-1:0] rise
);

  for (genvar i = 0; i < NDIV; i++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_in[i];
    end
    assign rise[i] = sig_in[i] & ~prev_q;
  end

endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import fl_pd_pkg::*;
#(
  parameter int NDIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            pd_arm,
  input  logic            pd_defer,
  input  logic            div_reset,
  input  logic            cp_float,
  input  logic [NDIV-1:0] div_rise,
  output logic            pwr_down,
  output logic            cp_hiz,
  output logic [NDIV-1:0] div_hold
);
  pd_state_t state_q, state_d;
  logic      imm_req, defer_req, down_next;

  assign imm_req   = !chip_en || (pd_arm && !pd_defer);
  assign defer_req = chip_en && pd_arm && pd_defer;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PD_RUN: begin
        if (imm_req)        state_d = PD_DOWN;
        else if (defer_req) state_d = PD_ARMED;
      end
      PD_ARMED: begin
        if (imm_req)         state_d = PD_DOWN;
        else if (!defer_req) state_d = PD_RUN;
        else if (|div_rise)  state_d = PD_DOWN;
      end
      PD_DOWN: begin
        if (!imm_req && !defer_req) state_d = PD_RUN;
      end
      default: state_d = PD_RUN;
    endcase
  end

  assign down_next = (state_d == PD_DOWN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PD_RUN;
      cp_hiz  <= 1'b0;
    end else begin
      state_q <= state_d;
      cp_hiz  <= down_next || div_reset || cp_float;
    end
  end

  // One hold register per divider, all loaded from the same term
  for (genvar i = 0; i < NDIV; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) div_hold[i] <= 1'b0;
      else        div_hold[i] <= down_next || div_reset;
    end
  end

  assign pwr_down = (state_q == PD_DOWN);

  p_ce_low_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> pwr_down);

  p_async_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && pd_arm && !pd_defer) |=> pwr_down);

  p_defer_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RUN && chip_en && pd_arm && pd_defer) |=> !pwr_down);

  p_down_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (cp_hiz && (&div_hold)));

  p_reset_no_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RUN && chip_en && !pd_arm) |=> !pwr_down);

  p_hold_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((&div_hold) || !(|div_hold)));

endmodule

// File: rtl/fl_pd_ctrl.sv
module fl_pd_ctrl #(
  parameter int CODE_W = 3,
  parameter int TC_W   = 4,
  parameter int NDIV   = 2,
  parameter int BASE   = 3,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_enable,
  input  logic              fl_timed,
  input  logic              gain_wr,
  input  logic              gain_wdata,
  input  logic [TC_W-1:0]   tmo_code,
  input  logic [CODE_W-1:0] icp_slow,
  input  logic [CODE_W-1:0] icp_fast,
  input  logic              chip_en,
  input  logic              pd_arm,
  input  logic              pd_defer,
  input  logic              div_reset,
  input  logic              cp_float,
  input  logic              pfd_tick,
  input  logic [NDIV-1:0]   div_out,
  output logic [CODE_W-1:0] icp_sel,
  output logic              cp_hiz,
  output logic              pwr_down,
  output logic [NDIV-1:0]   div_hold
);
  logic            gain_q;
  logic            expire;
  logic            tmr_run;
  logic            tmr_restart;
  logic [NDIV-1:0] div_rise;

  assign tmr_run     = fl_enable && fl_timed && gain_q && !pwr_down;
  assign tmr_restart = gain_wr && gain_wdata;

  fl_timeout_timer #(.TC_W(TC_W), .BASE(BASE), .STEP(STEP)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (tmr_run),
    .restart  (tmr_restart),
    .tick     (pfd_tick),
    .tmo_code (tmo_code),
    .expire   (expire)
  );

  fl_gain_ctrl #(.CODE_W(CODE_W)) u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .gain_wr    (gain_wr),
    .gain_wdata (gain_wdata),
    .expire     (expire),
    .icp_slow   (icp_slow),
    .icp_fast   (icp_fast),
    .gain_q     (gain_q),
    .icp_sel    (icp_sel)
  );

  pd_edge_det #(.NDIV(NDIV)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (div_out),
    .rise   (div_rise)
  );

  pd_seq #(.NDIV(NDIV)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .pd_arm    (pd_arm),
    .pd_defer  (pd_defer),
    .div_reset (div_reset),
    .cp_float  (cp_float),
    .div_rise  (div_rise),
    .pwr_down  (pwr_down),
    .cp_hiz    (cp_hiz),
    .div_hold  (div_hold)
  );

  // R9: no timeout can complete while powered down
  p_no_expire_in_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !expire);

  // R3: software-exit mode never produces a timer expiry
  p_soft_mode_no_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_enable && !fl_timed) |-> !expire);

endmodule

// File: tb/sim_fl_pd_ctrl.sv
module sim_fl_pd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fl_enable = 1'b0, fl_timed = 1'b0;
  logic       gain_wr = 1'b0, gain_wdata = 1'b0;
  logic [3:0] tmo_code = 4'd0;
  logic [2:0] icp_slow = 3'd1, icp_fast = 3'd6;
  logic       chip_en = 1'b1, pd_arm = 1'b0, pd_defer = 1'b0;
  logic       div_reset = 1'b0, cp_float = 1'b0, pfd_tick = 1'b0;
  logic [1:0] div_out = 2'b00;
  logic [2:0] icp_sel;
  logic       cp_hiz, pwr_down;
  logic [1:0] div_hold;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fl_pd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fl_enable(fl_enable), .fl_timed(fl_timed),
    .gain_wr(gain_wr), .gain_wdata(gain_wdata), .tmo_code(tmo_code),
    .icp_slow(icp_slow), .icp_fast(icp_fast), .chip_en(chip_en),
    .pd_arm(pd_arm), .pd_defer(pd_defer), .div_reset(div_reset),
    .cp_float(cp_float), .pfd_tick(pfd_tick), .div_out(div_out),
    .icp_sel(icp_sel), .cp_hiz(cp_hiz), .pwr_down(pwr_down), .div_hold(div_hold)
  );

  // {fl_enable, fl_timed, gain_wdata, icp_slow, icp_fast, expected icp_sel}
  localparam int NVEC = 7;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 3'd2, 3'd7, 3'd7},
    {1'b0, 1'b0, 1'b0, 3'd2, 3'd7, 3'd2},
    {1'b1, 1'b0, 1'b1, 3'd1, 3'd5, 3'd5},
    {1'b1, 1'b0, 1'b0, 3'd1, 3'd5, 3'd1},
    {1'b0, 1'b0, 1'b1, 3'd0, 3'd4, 3'd4},
    {1'b1, 1'b1, 1'b0, 3'd6, 3'd3, 3'd6},
    {1'b1, 1'b1, 1'b1, 3'd6, 3'd3, 3'd3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_gain(input logic v);
    gain_wdata = v;
    gain_wr = 1'b1;
    @(negedge clk);
    gain_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pfd_tick = 1'b1;
      @(negedge clk);
      pfd_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pd_outs(input string req, input logic pd, input logic hiz, input logic [1:0] hold);
    chk(req, {7'd0, pwr_down}, {7'd0, pd});
    chk(req, {7'd0, cp_hiz}, {7'd0, hiz});
    chk(req, {6'd0, div_hold}, {6'd0, hold});
  endtask

  task automatic timed_run(input string req, input logic [3:0] code);
    int len;
    len = 3 + 4 * code;
    tmo_code = code; fl_enable = 1'b1; fl_timed = 1'b1;
    write_gain(1'b1);
    ticks(len - 1);
    chk(req, {5'd0, icp_sel}, {5'd0, icp_fast});
    ticks(1);
    chk(req, {5'd0, icp_sel}, {5'd0, icp_slow});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1: reset state
    pd_outs("R1", 1'b0, 1'b0, 2'b00);
    chk("R1", {5'd0, icp_sel}, {5'd0, icp_slow});
    rst_n = 1'b1;
    cyc(1);
    pd_outs("R1", 1'b0, 1'b0, 2'b00);
    chk("R1", {5'd0, icp_sel}, {5'd0, icp_slow});

    // R2/R3/R4 table walk: code after a single write
    for (int v = 0; v < NVEC; v++) begin
      fl_enable = VEC[v][11]; fl_timed = VEC[v][10];
      icp_slow = VEC[v][8:6]; icp_fast = VEC[v][5:3];
      tmo_code = 4'd15;
      write_gain(VEC[v][9]);
      chk("R2", {5'd0, icp_sel}, {5'd0, VEC[v][2:0]});
    end
    write_gain(1'b0);
    icp_slow = 3'd1; icp_fast = 3'd6;

    // R2: disabled fastlock keeps the fast code forever
    fl_enable = 1'b0; fl_timed = 1'b1; tmo_code = 4'd0;
    write_gain(1'b1);
    ticks(70);
    chk("R2", {5'd0, icp_sel}, {5'd0, 3'd6});
    write_gain(1'b0);
    chk("R2", {5'd0, icp_sel}, {5'd0, 3'd1});

    // R3: software exit ignores ticks
    fl_enable = 1'b1; fl_timed = 1'b0;
    write_gain(1'b1);
    ticks(100);
    chk("R3", {5'd0, icp_sel}, {5'd0, 3'd6});
    write_gain(1'b0);
    chk("R3", {5'd0, icp_sel}, {5'd0, 3'd1});

    // R4: timed exit at 3, 11 and 63 ticks
    timed_run("R4", 4'd0);
    timed_run("R4", 4'd2);
    timed_run("R4", 4'd15);
    fl_enable = 1'b0;
    cyc(1);
    chk("R4", {5'd0, icp_sel}, {5'd0, 3'd1});

    // R5: a rewrite restarts the count
    fl_enable = 1'b1; fl_timed = 1'b1; tmo_code = 4'd2;
    write_gain(1'b1);
    ticks(6);
    write_gain(1'b1);
    ticks(10);
    chk("R5", {5'd0, icp_sel}, {5'd0, 3'd6});
    ticks(1);
    chk("R5", {5'd0, icp_sel}, {5'd0, 3'd1});

    // R9: timer held during power-down
    write_gain(1'b1);
    ticks(5);
    pd_arm = 1'b1; pd_defer = 1'b0;
    cyc(1);
    pd_outs("R9", 1'b1, 1'b1, 2'b11);
    ticks(20);
    chk("R9", {5'd0, icp_sel}, {5'd0, 3'd6});
    pd_arm = 1'b0;
    cyc(1);
    pd_outs("R12", 1'b0, 1'b0, 2'b00);
    ticks(10);
    chk("R9", {5'd0, icp_sel}, {5'd0, 3'd6});
    ticks(1);
    chk("R9", {5'd0, icp_sel}, {5'd0, 3'd1});
    fl_enable = 1'b0;

    // R6: chip enable low overrides the programmed bits
    pd_arm = 1'b1; pd_defer = 1'b1; chip_en = 1'b0;
    cyc(1);
    pd_outs("R6", 1'b1, 1'b1, 2'b11);
    pd_arm = 1'b0; pd_defer = 1'b0;
    cyc(2);
    chk("R6", {7'd0, pwr_down}, 8'd1);
    chip_en = 1'b1;
    cyc(1);
    pd_outs("R12", 1'b0, 1'b0, 2'b00);

    // R7: immediate programmed power-down
    pd_arm = 1'b1; pd_defer = 1'b0;
    cyc(1);
    pd_outs("R7", 1'b1, 1'b1, 2'b11);
    pd_arm = 1'b0;
    cyc(1);
    pd_outs("R12", 1'b0, 1'b0, 2'b00);

    // R8: deferred power-down waits for a divider rise, each divider in turn
    for (int d = 0; d < 2; d++) begin
      pd_arm = 1'b1; pd_defer = 1'b1;
      cyc(1);
      chk("R8", {7'd0, pwr_down}, 8'd0);
      cyc(4);
      pd_outs("R8", 1'b0, 1'b0, 2'b00);
      div_out[d] = 1'b1;
      cyc(1);
      pd_outs("R8", 1'b1, 1'b1, 2'b11);
      pd_arm = 1'b0; pd_defer = 1'b0; div_out = 2'b00;
      cyc(1);
      pd_outs("R12", 1'b0, 1'b0, 2'b00);
    end

    // R10: divider reset holds without powering down, even when armed
    pd_arm = 1'b1; pd_defer = 1'b1; div_reset = 1'b1;
    cyc(1);
    pd_outs("R10", 1'b0, 1'b1, 2'b11);
    cyc(3);
    chk("R10", {7'd0, pwr_down}, 8'd0);
    pd_arm = 1'b0; pd_defer = 1'b0; div_reset = 1'b0;
    cyc(1);
    pd_outs("R12", 1'b0, 1'b0, 2'b00);

    // R11: three-state field floats the pump only
    cp_float = 1'b1;
    cyc(1);
    pd_outs("R11", 1'b0, 1'b1, 2'b00);
    cp_float = 1'b0;
    cyc(1);
    chk("R11", {7'd0, cp_hiz}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule